// File: doc/BRIEF.md
# Seven-to-One Video Link Output Serializer

This block turns one parallel pixel word per pixel period into five seven-bit serial lanes plus a forwarded clock lane. Each pixel word holds video bits, an auxiliary control word that replaces the video bits while the data-enable flag is low, the two sync flags and the data-enable flag itself. The block runs on the fast bit clock. A strobe, `bit_en`, marks each bit slot, so seven strobes make one pixel period. The analog line drivers, clock multiplication and the upstream receiver lie outside this block.

The color-depth input sets how many lanes carry data. Wide mode packs 32 video bits onto all five lanes. Narrow mode packs 24 bits onto the first four lanes, and the fifth lane sits idle. The outputs are gated. Data flows only while output enable is set and the active-low lock input is low. Otherwise every lane, the clock lane included, drives a constant low. A mode input then picks whether each lane also raises its high-impedance flag. The lock and hot-plug status signals pass straight through and are never gated. Every control input is sampled only at the pixel-period boundary, so the block never emits a partial word.

Top module: `vlink_serializer`

## Requirements
- R1: Each lane sends bit 6 first and bit 0 last, one bit per `bit_en` strobe. Bit 0 of one period is followed directly by bit 6 of the next. While `bit_en` is low, every output holds its value.
- R2: The pixel word (`pix_video`, `pix_aux`, `pix_de`, `pix_vs`, `pix_hs`, `col_wide`) is captured only on the strobed edge that ends a period. Changes at any other time do not affect the word being sent.
- R3: Lane 2 (C) carries data enable in bit 6, vertical sync in bit 5 and horizontal sync in bit 4.
- R4: In wide mode (`col_wide`=1), the 32 data bits fill these positions in order: lane 0 bits 0..6 (index 0..6), lane 1 bits 0..6 (7..13), lane 2 bits 0..3 (14..17), lane 3 bits 0..6 (18..24) and lane 4 bits 0..6 (25..31).
- R5: In narrow mode (`col_wide`=0), data bits 0..23 fill lane 0 bits 0..6, lane 1 bits 0..6, lane 2 bits 0..3 and lane 3 bits 0..5. Lane 3 bit 6 is sent as 0. While enabled, lane 4 drives low with its high-impedance flag set.
- R6: When `pix_de` is 0, `pix_aux` takes the place of `pix_video` in the data positions.
- R7: When `out_en`=1 and `lock_n`=0 at the boundary, the lanes carry the mapped word for the next period and the high-impedance flags of the active lanes are 0.
- R8: When `out_en`=0 or `lock_n`=1 at the boundary, all data lanes and the clock lane drive 0 for the next period, and every high-impedance flag equals `dis_hiz`.
- R9: While enabled, the clock lane sends the pattern 1100011 with its bit 6 first, so each period begins on a high clock level.
- R10: `out_en`, `lock_n` and `dis_hiz` take effect only at a period boundary.
- R11: `lock_n_out` always equals `lock_n`, and `hpd_out` always equals `hpd`, whatever the gating state.
- R12: After reset the slot counter is at bit 6 and every lane, clock and flag output is 0. The first new word is captured on the seventh strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-slot strobe, seven per pixel period |
| col_wide | input | 1 | 1: five-lane 32-bit mode, 0: four-lane 24-bit mode |
| pix_video | input | 32 | Video bits of the pixel word |
| pix_aux | input | 32 | Auxiliary control bits sent while data enable is low |
| pix_de | input | 1 | Data enable |
| pix_vs | input | 1 | Vertical sync |
| pix_hs | input | 1 | Horizontal sync |
| out_en | input | 1 | Output enable |
| dis_hiz | input | 1 | When disabled: 1 raises the high-impedance flags, 0 drives low only |
| lock_n | input | 1 | Active-low link lock indicator |
| hpd | input | 1 | Hot-plug status |
| lane_ser | output | 5 | Serial data, one bit per lane |
| lane_hiz | output | 5 | High-impedance request per lane |
| clk_ser | output | 1 | Forwarded clock lane level |
| clk_hiz | output | 1 | High-impedance request for the clock lane |
| lock_n_out | output | 1 | Ungated lock status |
| hpd_out | output | 1 | Ungated hot-plug status |

## Verification
Inputs sampled at a boundary show up at the outputs in the bit-6 slot one clock after the strobed edge that ends the period. Each later bit appears one strobed edge after the bit before it, and nothing moves on unstrobed edges. The status pass-through is due in the same cycle. The bench keeps its own slot count. It sets the next word's inputs only in the bit-0 slot and scrambles every input during the other slots and during stalls. It samples on the falling edge, so each check sees the bit of the slot it expects. Each comparison uses the values captured at the boundary, never the live inputs.

// File: rtl/vlink_pkg.sv
package vlink_pkg;
  localparam int BITS_PER_WORD = 7;
  localparam int LANE_COUNT    = 5;
  localparam int CTRL_SLOTS    = 3;
  localparam int VID_BITS      = LANE_COUNT * BITS_PER_WORD - CTRL_SLOTS;
  localparam int LANE_C        = 2;
  localparam int LANE_D        = 3;
  localparam int LANE_E        = 4;
  localparam int DE_POS        = 6;
  localparam int VS_POS        = 5;
  localparam int HS_POS        = 4;
  localparam logic [BITS_PER_WORD-1:0] CLK_PATTERN = 7'b1100011;

  // Whether a lane position carries a data bit in the given color mode.
  function automatic logic pos_is_data(logic wide, int lane, int b);
    if (lane == LANE_C && b >= HS_POS) return 1'b0;
    if (lane == LANE_D && b == BITS_PER_WORD - 1 && !wide) return 1'b0;
    if (lane == LANE_E && !wide) return 1'b0;
    return 1'b1;
  endfunction

  // Whether a lane is driven at all in the given color mode.
  function automatic logic lane_in_use(logic wide, int lane);
    return wide || (lane != LANE_E);
  endfunction
endpackage

// File: rtl/vlink_slot_ctr.sv
module vlink_slot_ctr #(
  parameter int BITS_PER_WORD = 7,
  localparam int SW = $clog2(BITS_PER_WORD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  output logic [SW-1:0] slot,
  output logic          frame_load
);
  localparam logic [SW-1:0] LAST = SW'(BITS_PER_WORD - 1);

  assign frame_load = bit_en && (slot == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      slot <= '0;
    else if (bit_en) slot <= frame_load ? '0 : slot + SW'(1);
  end

  // R1: slot counter stays inside one period
  p_slot_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= LAST);
  // R1: no advance without a strobe
  p_slot_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(slot));
  // R1: a boundary always wraps to bit 6 slot
  p_slot_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> slot == '0);
endmodule

// File: rtl/vlink_lane_map.sv
module vlink_lane_map
  import vlink_pkg::*;
#(
  parameter int NLANE = LANE_COUNT,
  parameter int BITS  = BITS_PER_WORD,
  parameter int VID_W = VID_BITS,
  localparam int IW   = $clog2(VID_W)
) (
  input  logic                       wide,
  input  logic                       de,
  input  logic                       vs,
  input  logic                       hs,
  input  logic [VID_W-1:0]           video,
  input  logic [VID_W-1:0]           aux,
  output logic [NLANE-1:0][BITS-1:0] frame
);
  logic [VID_W-1:0] word;
  assign word = de ? video : aux;

  always_comb begin
    logic [IW:0] k;
    k = '0;
    frame = '0;
    for (int l = 0; l < NLANE; l++) begin
      for (int b = 0; b < BITS; b++) begin
        if (pos_is_data(wide, l, b) && (k < (IW+1)'(VID_W))) begin
          frame[l][b] = word[k[IW-1:0]];
          k = k + (IW+1)'(1);
        end
      end
    end
    frame[LANE_C][DE_POS] = de;
    frame[LANE_C][VS_POS] = vs;
    frame[LANE_C][HS_POS] = hs;
  end
endmodule

// File: rtl/vlink_lane_drive.sv
module vlink_lane_drive
  import vlink_pkg::*;
#(
  parameter int NLANE = LANE_COUNT,
  parameter int BITS  = BITS_PER_WORD,
  localparam int SW   = $clog2(BITS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_load,
  input  logic [SW-1:0]              slot,
  input  logic [NLANE-1:0][BITS-1:0] frame_d,
  input  logic                       wide_d,
  input  logic                       en_d,
  input  logic                       hiz_d,
  output logic [NLANE-1:0]           lane_ser,
  output logic [NLANE-1:0]           lane_hiz,
  output logic                       clk_ser,
  output logic                       clk_hiz
);
  logic [NLANE-1:0][BITS-1:0] frame_q;
  logic                       wide_q, en_q, hiz_q;
  logic [SW-1:0]              bit_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      wide_q  <= 1'b0;
      en_q    <= 1'b0;
      hiz_q   <= 1'b0;
    end else if (frame_load) begin
      frame_q <= frame_d;
      wide_q  <= wide_d;
      en_q    <= en_d;
      hiz_q   <= hiz_d;
    end
  end

  assign bit_sel = SW'(BITS - 1) - slot;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic used;
    assign used        = lane_in_use(wide_q, l);
    assign lane_ser[l] = en_q && used && frame_q[l][bit_sel];
    assign lane_hiz[l] = en_q ? !used : hiz_q;
  end

  assign clk_ser = en_q && CLK_PATTERN[bit_sel];
  assign clk_hiz = !en_q && hiz_q;

  // R9: an enabled period opens on a high clock level
  p_clk_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && slot == '0) |-> clk_ser);
  // R9: the clock lane is low in the middle slot
  p_clk_mid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SW'(3)) |-> !clk_ser);
endmodule

// File: rtl/vlink_serializer.sv
module vlink_serializer
  import vlink_pkg::*;
#(
  parameter int NLANE = LANE_COUNT,
  parameter int BITS  = BITS_PER_WORD,
  parameter int VID_W = VID_BITS,
  localparam int SW   = $clog2(BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             col_wide,
  input  logic [VID_W-1:0] pix_video,
  input  logic [VID_W-1:0] pix_aux,
  input  logic             pix_de,
  input  logic             pix_vs,
  input  logic             pix_hs,
  input  logic             out_en,
  input  logic             dis_hiz,
  input  logic             lock_n,
  input  logic             hpd,
  output logic [NLANE-1:0] lane_ser,
  output logic [NLANE-1:0] lane_hiz,
  output logic             clk_ser,
  output logic             clk_hiz,
  output logic             lock_n_out,
  output logic             hpd_out
);
  logic [SW-1:0]              slot;
  logic                       frame_load;
  logic                       link_up;
  logic [NLANE-1:0][BITS-1:0] frame_d;

  assign link_up    = out_en && !lock_n;
  assign lock_n_out = lock_n;
  assign hpd_out    = hpd;

  vlink_slot_ctr #(.BITS_PER_WORD(BITS)) u_slot (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .slot(slot), .frame_load(frame_load)
  );

  vlink_lane_map #(.NLANE(NLANE), .BITS(BITS), .VID_W(VID_W)) u_map (
    .wide(col_wide), .de(pix_de), .vs(pix_vs), .hs(pix_hs),
    .video(pix_video), .aux(pix_aux), .frame(frame_d)
  );

  vlink_lane_drive #(.NLANE(NLANE), .BITS(BITS)) u_drive (
    .clk(clk), .rst_n(rst_n), .frame_load(frame_load), .slot(slot),
    .frame_d(frame_d), .wide_d(col_wide), .en_d(link_up), .hiz_d(dis_hiz),
    .lane_ser(lane_ser), .lane_hiz(lane_hiz),
    .clk_ser(clk_ser), .clk_hiz(clk_hiz)
  );

  // R3: data enable leads lane C right after the boundary
  p_de_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> lane_ser[LANE_C] == ($past(link_up) && $past(pix_de)));
  // R8: a disabled period is low everywhere with flags from the mode input
  p_gate_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_load && !link_up) |=>
      (lane_ser == '0 && !clk_ser && lane_hiz == {NLANE{$past(dis_hiz)}}));
  // R10: flags move only at a boundary
  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> ($stable(lane_hiz) && $stable(clk_hiz)));
  // R1: no output moves without a strobe
  p_out_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(lane_ser) && $stable(clk_ser)));
  // R5: an enabled narrow period idles lane E
  p_narrow_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_load && link_up && !col_wide) |=> (lane_hiz[LANE_E] && !lane_ser[LANE_E]));
endmodule

// File: tb/vlink_serializer_bench.sv
module vlink_serializer_bench;
  logic        clk = 1'b0;
  logic        rst_n, bit_en, col_wide, pix_de, pix_vs, pix_hs;
  logic        out_en, dis_hiz, lock_n, hpd;
  logic [31:0] pix_video, pix_aux;
  logic [4:0]  lane_ser, lane_hiz;
  logic        clk_ser, clk_hiz, lock_n_out, hpd_out;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // values captured for the period being sent
  bit        c_wide, c_de, c_vs, c_hs, c_en, c_hizm;
  bit [31:0] c_video, c_aux;
  // values chosen for the next period
  bit        n_wide, n_de, n_vs, n_hs, n_oe, n_lockn, n_hizm;
  bit [31:0] n_video, n_aux;

  always #10 clk = ~clk;

  vlink_serializer u_vlink_serializer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .col_wide(col_wide),
    .pix_video(pix_video), .pix_aux(pix_aux), .pix_de(pix_de),
    .pix_vs(pix_vs), .pix_hs(pix_hs), .out_en(out_en), .dis_hiz(dis_hiz),
    .lock_n(lock_n), .hpd(hpd), .lane_ser(lane_ser), .lane_hiz(lane_hiz),
    .clk_ser(clk_ser), .clk_hiz(clk_hiz), .lock_n_out(lock_n_out),
    .hpd_out(hpd_out)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Data index of a lane position, -1 where no data bit goes
  function automatic int data_index(bit wide, int l, int b);
    case (l)
      0: return b;
      1: return 7 + b;
      2: return (b < 4) ? 14 + b : -1;
      3: return (b < 6 || wide) ? 18 + b : -1;
      default: return wide ? 25 + b : -1;
    endcase
  endfunction

  function automatic bit exp_bit(int l, int b);
    bit [31:0] w;
    int idx;
    w = c_de ? c_video : c_aux;
    if (l == 2 && b == 6) return c_de;
    if (l == 2 && b == 5) return c_vs;
    if (l == 2 && b == 4) return c_hs;
    idx = data_index(c_wide, l, b);
    return (idx >= 0) ? w[idx] : 1'b0;
  endfunction

  function automatic bit used(int l);
    return c_wide || l != 4;
  endfunction

  task automatic check_slot(string tag, int p);
    logic [4:0] es, eh;
    logic [6:0] pat;
    pat = 7'b1100011;
    for (int l = 0; l < 5; l++) begin
      es[l] = c_en && used(l) && exp_bit(l, p);
      eh[l] = c_en ? !used(l) : c_hizm;
    end
    check(tag, 32'(lane_ser), 32'(es));
    check(c_en ? "R7 flags" : "R8 flags", 32'(lane_hiz), 32'(eh));
    check("R9 clock", {30'd0, clk_ser, clk_hiz},
          {30'd0, c_en && pat[p], !c_en && c_hizm});
    check("R11 status", {30'd0, lock_n_out, hpd_out}, {30'd0, lock_n, hpd});
  endtask

  task automatic scramble();
    col_wide  = 1'($urandom);
    pix_video = $urandom;
    pix_aux   = $urandom;
    pix_de    = 1'($urandom);
    pix_vs    = 1'($urandom);
    pix_hs    = 1'($urandom);
    out_en    = 1'($urandom);
    dis_hiz   = 1'($urandom);
    lock_n    = 1'($urandom);
    hpd       = 1'($urandom);
  endtask

  task automatic apply_next();
    col_wide = n_wide; pix_video = n_video; pix_aux = n_aux;
    pix_de = n_de; pix_vs = n_vs; pix_hs = n_hs;
    out_en = n_oe; lock_n = n_lockn; dis_hiz = n_hizm;
  endtask

  task automatic pick_next(int f);
    n_wide = 1'($urandom); n_video = $urandom; n_aux = $urandom;
    n_de = 1'b1; n_vs = 1'($urandom); n_hs = 1'($urandom);
    n_oe = 1'b1; n_lockn = 1'b0; n_hizm = 1'($urandom);
    case (f)
      0: n_wide = 1'b1;                                   // R4
      1: n_wide = 1'b0;                                   // R5
      2: n_de = 1'b0;                                     // R6
      3: begin n_oe = 1'b0; n_hizm = 1'b1; end            // R8
      4: begin n_lockn = 1'b1; n_hizm = 1'b0; end         // R8
      5: begin n_oe = 1'b1; n_lockn = 1'b0; end           // R7
      6: begin n_video = 32'd0; n_vs = 1'b1; n_hs = 1'b0; end // R3
      7: begin n_video = 32'hFFFF_FFFF; n_wide = 1'b0; end    // R5
      default: begin
        n_de = 1'($urandom); n_oe = 1'($urandom % 4 != 0);
        n_lockn = 1'($urandom % 4 == 0);
      end
    endcase
  endtask

  function automatic string tag_of(int f);
    case (f)
      0: return "R12 reset";
      1: return "R4 wide map";
      2: return "R5 narrow map";
      3: return "R6 aux";
      4, 5: return "R8 disabled";
      6: return "R7 enabled";
      7: return "R3 ctrl slots";
      8: return "R5 narrow ones";
      default: return "R2 R10 capture";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    process_seed();
    rst_n = 1'b0; bit_en = 1'b0;
    col_wide = 0; pix_video = 0; pix_aux = 0; pix_de = 0; pix_vs = 0;
    pix_hs = 0; out_en = 0; dis_hiz = 0; lock_n = 0; hpd = 0;
    c_wide = 0; c_de = 0; c_vs = 0; c_hs = 0; c_en = 0; c_hizm = 0;
    c_video = 0; c_aux = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 reset outputs", {20'd0, lane_ser, lane_hiz, clk_ser, clk_hiz},
          32'd0);
    rst_n = 1'b1;
    for (int f = 0; f < 260; f++) begin
      for (int i = 0; i < 7; i++) begin
        int p;
        p = 6 - i;
        check_slot(tag_of(f), p);
        if (f >= 9) begin
          int nst;
          nst = $urandom % 3;
          for (int s = 0; s < nst; s++) begin
            bit_en = 1'b0;
            scramble();
            @(negedge clk);
            check_slot("R1 stall hold", p);
          end
        end
        if (i == 6) begin
          pick_next(f);
          apply_next();
        end else begin
          scramble();
        end
        bit_en = 1'b1;
        @(negedge clk);
      end
      c_wide = n_wide; c_video = n_video; c_aux = n_aux; c_de = n_de;
      c_vs = n_vs; c_hs = n_hs; c_en = n_oe && !n_lockn; c_hizm = n_hizm;
    end
    finish_run();
  end

  task automatic process_seed();
    int unsigned s;
    s = $urandom(32'h5EED_1234);
    if (s == 0) tests = 0;
  endtask
endmodule